// File: doc/BRIEF.md
# Bit-Expanding Phase-Shifted Serializer

This block turns response bytes into a stream of 8-bit modulation words for a synchronous serial transmitter. Each data bit becomes a whole word of ones or zeros. The word stream can be delayed by a sub-word offset of 0 to 7 bit times, so that a response lines up finely with the reader's time reference. Each outgoing word therefore joins the tail of the word sent before it to the head of the current expanded word.

Bytes arrive on a valid/ready handshake. The byte that ends a frame is marked with a last flag. Words leave under a transmitter-ready signal. In slow mode every expanded word is repeated four times; in fast mode it is sent once. After the final bit of a frame, one extra flush word carries out the bits that the shift still holds. A one-cycle done pulse then closes the frame. The mode and delay inputs must be held steady for the whole of a frame.

Top module: `bitword_serializer`

## Requirements
- R1: After reset, in_ready is 1 and tx_valid and done are both 0.
- R2: The bits of each byte are expanded most significant first: a 1 bit gives the word 8'hFF and a 0 bit gives 8'h00.
- R3: With slow_mode = 1 each expanded word is offered 4 times; with slow_mode = 0 it is offered once.
- R4: Each offered word equals the low byte of {P, E} >> shift_dly. Here E is the current expanded word and P is the expanded word of the previously accepted output word of the frame. This holds across byte boundaries.
- R5: While tx_valid is 1 and tx_ready is 0, tx_word stays unchanged and no repetition or bit is consumed.
- R6: After the last bit of the byte flagged in_last, exactly one flush word is offered. It equals the low byte of {P, 8'h00} >> shift_dly, so it is 8'h00 when shift_dly is 0.
- R7: P is zero at the start of every frame, including a frame that follows another, so the first word carries leading zeros.
- R8: done is 1 for exactly the one cycle that follows acceptance of the flush word.
- R9: in_ready is 1 only while no byte or flush word is pending, and it is never 1 while tx_valid is 1. A byte is taken when in_valid and in_ready are both 1.
- R10: With shift_dly = 0, every offered word is 8'h00 or 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Response byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| slow_mode | input | 1 | 1: each expanded word is sent 4 times |
| shift_dly | input | 3 | Sub-word delay in bit times |
| tx_ready | input | 1 | Transmitter takes the current word |
| tx_valid | output | 1 | A word is offered |
| tx_word | output | 8 | Modulation word |
| done | output | 1 | One-cycle pulse after the flush word is taken |

## Verification
The checker watches on every cycle that a stalled word holds steady (R5), that in_ready and tx_valid never overlap (R9), that done is a lone pulse with the output idle (R8), and that an unshifted stream only contains full or empty words (R10). Only the bench's scenarios can show the word order itself. It compares every accepted word against a model of the expansion, repetition, cross-word shift and flush for single-byte and multi-byte frames. It also covers back-to-back frames, where the previous word must restart at zero (R7), and stalls applied under random-looking backpressure.

// File: rtl/bitword_serializer.sv
module bitword_serializer #(
  parameter int SLOW_REPS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       slow_mode,
  input  logic [2:0] shift_dly,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_word,
  output logic       done
);

  localparam int REP_W = (SLOW_REPS > 2) ? $clog2(SLOW_REPS) : 1;
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(SLOW_REPS - 1);

  logic [7:0]       byte_q;
  logic [7:0]       prev_q;
  logic [2:0]       bit_q;
  logic [REP_W-1:0] rep_q;
  logic             busy_q;
  logic             last_q;
  logic             flush_q;
  logic             done_q;

  wire  [7:0]  cur_w    = byte_q[3'd7 - bit_q] ? 8'hFF : 8'h00;
  wire  [15:0] pair_w   = {prev_q, flush_q ? 8'h00 : cur_w} >> shift_dly;
  wire         fire     = tx_valid & tx_ready;
  wire         last_rep = !slow_mode || (rep_q == REP_LAST);

  assign tx_word  = pair_w[7:0];
  assign tx_valid = busy_q | flush_q;
  assign in_ready = !(busy_q | flush_q);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q  <= '0;
      prev_q  <= '0;
      bit_q   <= '0;
      rep_q   <= '0;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
      flush_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire & flush_q;
      if (in_valid && in_ready) begin
        byte_q <= in_data;
        last_q <= in_last;
        bit_q  <= '0;
        rep_q  <= '0;
        busy_q <= 1'b1;
      end
      if (fire && flush_q) begin
        flush_q <= 1'b0;
        prev_q  <= '0;
      end else if (fire) begin
        prev_q <= cur_w;
        if (last_rep) begin
          rep_q <= '0;
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            busy_q  <= 1'b0;
            flush_q <= last_q;
          end
        end else begin
          rep_q <= rep_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bitword_serializer_chk.sv
module bitword_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [2:0] shift_dly,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_word,
  input logic       done
);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word)));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && tx_valid));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!tx_valid && in_ready));

  assert_zero_delay_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && shift_dly == 3'd0) |-> (tx_word == 8'h00 || tx_word == 8'hFF));

endmodule

bind bitword_serializer bitword_serializer_chk chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .shift_dly(shift_dly),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_word(tx_word), .done(done)
);

// File: tb/bitword_serializer_test.sv
module bitword_serializer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       slow_mode = 1'b0;
  logic [2:0] shift_dly = '0;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_word;
  logic       done;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitword_serializer uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_last(in_last),
    .in_valid(in_valid), .in_ready(in_ready), .slow_mode(slow_mode),
    .shift_dly(shift_dly), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_word(tx_word), .done(done)
  );

  // {byte, slow, delay}
  localparam logic [11:0] VEC [12] = '{
    {8'hA5, 1'b0, 3'd0}, {8'h3C, 1'b0, 3'd3}, {8'h80, 1'b0, 3'd7},
    {8'h01, 1'b0, 3'd1}, {8'hFF, 1'b0, 3'd4}, {8'h00, 1'b0, 3'd5},
    {8'h96, 1'b1, 3'd2}, {8'h5A, 1'b1, 3'd0}, {8'hC3, 1'b1, 3'd6},
    {8'h7E, 1'b0, 3'd2}, {8'h81, 1'b1, 3'd7}, {8'h0F, 1'b0, 3'd0}
  };

  int applied = 0;
  int fails = 0;
  logic [7:0] fb [4];
  int fn;
  logic [7:0] exp_w [160];
  int nexp;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build_exp(input bit slow, input logic [2:0] d);
    logic [7:0] p, e;
    logic [15:0] t;
    p = 8'h00;
    nexp = 0;
    for (int b = 0; b < fn; b++)
      for (int i = 7; i >= 0; i--) begin
        e = fb[b][i] ? 8'hFF : 8'h00;
        for (int r = 0; r < (slow ? 4 : 1); r++) begin
          t = {p, e} >> d;
          exp_w[nexp] = t[7:0];
          nexp++;
          p = e;
        end
      end
    t = {p, 8'h00} >> d;
    exp_w[nexp] = t[7:0];
    nexp++;
  endtask

  task automatic run_frame(input bit slow, input logic [2:0] d, input bit bp, input string tag);
    int k, bi, cyc, acc_cyc;
    bit held, seen_done;
    logic [7:0] held_w;
    build_exp(slow, d);
    slow_mode = slow;
    shift_dly = d;
    k = 0; bi = 0; cyc = 0; acc_cyc = -10; held = 0; seen_done = 0; held_w = '0;
    while (!seen_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      tx_ready = bp ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
      in_valid = (bi < fn);
      in_data  = (bi < fn) ? fb[bi] : 8'h00;
      in_last  = (bi == fn - 1);
      #1;
      if (held) check(tx_valid && tx_word == held_w, "R5 stalled word held", {23'd0, tx_valid, tx_word}, {24'd1, held_w});
      held = tx_valid && !tx_ready;
      held_w = tx_word;
      if (in_ready && tx_valid) check(0, "R9 in_ready with tx_valid", 1, 0);
      if (done) begin
        seen_done = 1;
        check(k == nexp, "R6 word count at done", k, nexp);
        check(acc_cyc == cyc - 1, "R8 done one cycle after flush", acc_cyc, cyc - 1);
      end else if (in_valid && in_ready) begin
        bi++;
      end else if (tx_valid && tx_ready) begin
        if (k < nexp) check(tx_word == exp_w[k], (k == nexp - 1) ? {tag, " R6 flush"} : tag, tx_word, exp_w[k]);
        else check(0, "R6 extra word", tx_word, 0);
        k++;
        if (k == nexp) acc_cyc = cyc;
      end
    end
    check(seen_done, "R8 done seen", seen_done, 1);
    in_valid = 1'b0;
    tx_ready = 1'b0;
    @(negedge clk);
    #1;
    check(!done && in_ready && !tx_valid, "R8 done single cycle", {done, in_ready, tx_valid}, 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(in_ready && !tx_valid && !done, "R1 reset state", {in_ready, tx_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(in_ready && !tx_valid && !done, "R1 after release", {in_ready, tx_valid, done}, 3'b100);

    // R2 R3 R4 R6 R10: single-byte frames across modes and delays
    for (int v = 0; v < 12; v++) begin
      fn = 1;
      fb[0] = VEC[v][11:4];
      run_frame(VEC[v][3], VEC[v][2:0], 1'b0, "R2 R3 R4 table word");
    end

    // R4: previous word carried across byte boundaries
    fn = 3; fb[0] = 8'h01; fb[1] = 8'h80; fb[2] = 8'h55;
    run_frame(1'b0, 3'd3, 1'b0, "R4 multi-byte");

    // R5: backpressure in slow mode over a multi-byte frame
    fn = 4; fb[0] = 8'hB1; fb[1] = 8'h6E; fb[2] = 8'h00; fb[3] = 8'hF0;
    run_frame(1'b1, 3'd5, 1'b1, "R5 R3 backpressure");

    // R7: frame ending on a 1 bit followed by a frame starting on a 1 bit
    fn = 1; fb[0] = 8'h01;
    run_frame(1'b0, 3'd3, 1'b0, "R7 first frame");
    fn = 1; fb[0] = 8'h80;
    run_frame(1'b0, 3'd3, 1'b0, "R7 second frame");
    check(exp_w[0] == 8'h1F, "R7 model leading zeros", exp_w[0], 8'h1F);

    // R6 R10: delay zero flush is all zeros, with stalls
    fn = 2; fb[0] = 8'hFF; fb[1] = 8'h01;
    run_frame(1'b0, 3'd0, 1'b1, "R10 R6 zero delay");

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule